// File: doc/BRIEF.md
# Image Sensor Row Readout Sequencer

This block sits on the host side of a CMOS image sensor whose digitised rows leave the part on a wide parallel bus. It runs the per-row handshake with the sensor. It pulses an active-low row-start strobe with a row address, then waits for the sensor's active-low conversion-done strobe. It then pulls the active-low load/shift and data-read enables and captures one group of pixels per clock until the row is drained. Each captured group leaves the block as one stream word. The word carries the row address, a column-group index and a valid flag.

Conversion and readout are separate engines. When the run input stays high, the next row's conversion starts a fixed number of clocks after the data-read enable of the current row falls. The sensor therefore digitises row N+1 while row N is still being shifted out. The start of capture is aligned to a fixed count of rising edges after the load/shift enable falls. A programmable timeout covers a sensor that never reports conversion done.

Top module: `sensor_row_sequencer`

## Requirements
- R1: While reset is asserted, `row_start_n`, `load_shift_n` and `read_en_n` are high, `out_valid`, `frame_start` and `err` are low, and `row_addr` is 0.
- R2: A row start is a single-cycle low pulse on `row_start_n`, and during that pulse `row_addr` holds the address being started. Successive starts use consecutive addresses, and the address after ROW_COUNT-1 is 0.
- R3: `frame_start` is high in exactly the cycles in which a row start is issued for address 0.
- R4: `load_shift_n` falls only after `row_done_n` has been sampled low since the row's start, and never more than once per done strobe. `read_en_n` falls in the same cycle as `load_shift_n`, and both stay low until the row's last group is captured.
- R5: The first group of a row is taken from `sens_data` at the LOAD_LAT-th rising clock edge (default third) after `load_shift_n` goes low. Each following edge takes the next group.
- R6: Each row produces exactly GROUPS (default 128) consecutive cycles of `out_valid`. `out_col` runs from 0 upward by one in those cycles, and `out_row` equals the address that was given at that row's start.
- R7: Sensor port k (k = 0..PORTS-1) occupies bits [PIX_W*k +: PIX_W] of `sens_data`, so group g port k is pixel column 10g+k+1. The same bit positions are kept in `out_data`.
- R8: While `run` is high and a row is being read, the next `row_start_n` pulse comes exactly OVL_GAP (default 2) cycles after `read_en_n` fell, so that it overlaps the readout.
- R9: If `row_done_n` is not sampled low within `tmo_limit` cycles after a row start, `err` is set, the conversion engine returns to idle and issues no further start while `err` is high. `err` clears once `run` is low.
- R10: With `run` low, no new row start is issued, and a row already started is still read out completely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sensor system clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| run | input | 1 | Keep issuing rows while high |
| tmo_limit | input | TMO_W | Cycles allowed between row start and conversion done |
| row_start_n | output | 1 | Active-low row conversion start pulse |
| row_addr | output | ROW_W | Row address, valid during the start pulse |
| row_done_n | input | 1 | Active-low conversion-done strobe from the sensor |
| load_shift_n | output | 1 | Active-low load of converted row into the sensor output register |
| read_en_n | output | 1 | Active-low data-read enable |
| sens_data | input | PORTS*PIX_W | Parallel pixel bus, one group per clock |
| frame_start | output | 1 | High with the start of row 0 |
| err | output | 1 | Conversion-done timeout flag |
| out_valid | output | 1 | Row-valid flag for the output word |
| out_data | output | PORTS*PIX_W | Captured pixel group |
| out_col | output | $clog2(GROUPS) | Column-group index of the output word |
| out_row | output | ROW_W | Row address of the output word |

## Verification
The hardest state to reach is the steady overlap. In that state a done strobe for row N+1 arrives while row N is still draining, and it must be held until the readout engine frees up. Reaching it requires a sensor model that answers every start after a short delay, so that conversion always finishes early and waits. The bench keeps `run` high for more rows than the address range holds. It measures the start-to-read-enable spacing on every overlapped row, and at the same time the scoreboard follows the address through its wrap. The timeout path needs a sensor that stays silent, so the bench mutes its done strobe for one row and probes `err` just before and just after the limit.

// File: rtl/rowseq_pkg.sv
package rowseq_pkg;
  typedef enum logic [1:0] {CV_IDLE, CV_STRT, CV_WAIT, CV_HOLD} cv_state_e;
  typedef enum logic [1:0] {RD_IDLE, RD_LAT, RD_CAP} rd_state_e;
endpackage

// File: rtl/rowseq_conv.sv
module rowseq_conv
  import rowseq_pkg::*;
#(
  parameter int ROW_W     = 10,
  parameter int ROW_COUNT = 1024,
  parameter int TMO_W     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [TMO_W-1:0] tmo_limit,
  input  logic             start_ok,
  input  logic             take,
  input  logic             row_done_n,
  output logic             row_start_n,
  output logic [ROW_W-1:0] row_addr,
  output logic             frame_start,
  output logic             hold,
  output logic [ROW_W-1:0] hold_row,
  output logic             err
);
  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROW_COUNT - 1);

  cv_state_e        st_q, st_d;
  logic [ROW_W-1:0] addr_q, addr_d, row_q, row_d;
  logic [TMO_W-1:0] cnt_q, cnt_d;
  logic             err_q, err_d;

  always_comb begin
    st_d   = st_q;
    addr_d = addr_q;
    row_d  = row_q;
    cnt_d  = cnt_q;
    err_d  = err_q;
    if (!run) err_d = 1'b0;
    case (st_q)
      CV_IDLE: if (run && !err_q && start_ok) st_d = CV_STRT;
      CV_STRT: begin
        row_d  = addr_q;
        addr_d = (addr_q == LAST_ROW) ? '0 : addr_q + ROW_W'(1);
        cnt_d  = '0;
        st_d   = CV_WAIT;
      end
      CV_WAIT: begin
        if (!row_done_n) begin
          st_d = CV_HOLD;
        end else if (cnt_q == tmo_limit - TMO_W'(1)) begin
          st_d  = CV_IDLE;
          err_d = 1'b1;
        end else begin
          cnt_d = cnt_q + TMO_W'(1);
        end
      end
      CV_HOLD: if (take) st_d = CV_IDLE;
      default: st_d = CV_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= CV_IDLE;
      addr_q <= '0;
      row_q  <= '0;
      cnt_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      addr_q <= addr_d;
      row_q  <= row_d;
      cnt_q  <= cnt_d;
      err_q  <= err_d;
    end
  end

  assign row_start_n = (st_q != CV_STRT);
  assign row_addr    = addr_q;
  assign frame_start = (st_q == CV_STRT) && (addr_q == '0);
  assign hold        = (st_q == CV_HOLD);
  assign hold_row    = row_q;
  assign err         = err_q;
endmodule

// File: rtl/rowseq_readout.sv
module rowseq_readout
  import rowseq_pkg::*;
#(
  parameter int PORTS    = 10,
  parameter int PIX_W    = 10,
  parameter int GROUPS   = 128,
  parameter int ROW_W    = 10,
  parameter int LOAD_LAT = 3,
  parameter int OVL_GAP  = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     hold,
  input  logic [ROW_W-1:0]         hold_row,
  input  logic [PORTS*PIX_W-1:0]   sens_data,
  output logic                     take,
  output logic                     start_ok,
  output logic                     load_shift_n,
  output logic                     read_en_n,
  output logic                     out_valid,
  output logic [PORTS*PIX_W-1:0]   out_data,
  output logic [$clog2(GROUPS)-1:0] out_col,
  output logic [ROW_W-1:0]         out_row
);
  localparam int GRP_W = $clog2(GROUPS);
  localparam int LAT_W = $clog2(LOAD_LAT) + 1;
  localparam int AGE_W = $clog2(OVL_GAP) + 1;
  localparam logic [GRP_W-1:0] LAST_GRP = GRP_W'(GROUPS - 1);
  localparam logic [LAT_W-1:0] LAT_END  = LAT_W'(LOAD_LAT - 2);
  localparam logic [AGE_W-1:0] AGE_TOP  = AGE_W'(OVL_GAP - 1);

  rd_state_e        st_q, st_d;
  logic [LAT_W-1:0] lat_q, lat_d;
  logic [GRP_W-1:0] grp_q, grp_d, col_q;
  logic [AGE_W-1:0] age_q, age_d;
  logic [ROW_W-1:0] row_q, row_d, orow_q;
  logic             vld_q, cap;
  logic [PIX_W-1:0] lane_q [PORTS];

  assign cap  = (st_q == RD_CAP);
  assign take = (st_q == RD_IDLE) && hold;

  always_comb begin
    st_d  = st_q;
    lat_d = lat_q;
    grp_d = grp_q;
    row_d = row_q;
    age_d = age_q;
    if (st_q != RD_IDLE && age_q < AGE_TOP) age_d = age_q + AGE_W'(1);
    case (st_q)
      RD_IDLE: if (hold) begin
        st_d  = RD_LAT;
        lat_d = '0;
        age_d = '0;
        row_d = hold_row;
      end
      RD_LAT: begin
        lat_d = lat_q + LAT_W'(1);
        if (lat_q == LAT_END) begin
          st_d  = RD_CAP;
          grp_d = '0;
        end
      end
      RD_CAP: begin
        if (grp_q == LAST_GRP) st_d = RD_IDLE;
        else                   grp_d = grp_q + GRP_W'(1);
      end
      default: st_d = RD_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= RD_IDLE;
      lat_q <= '0;
      grp_q <= '0;
      age_q <= '0;
      row_q <= '0;
    end else begin
      st_q  <= st_d;
      lat_q <= lat_d;
      grp_q <= grp_d;
      age_q <= age_d;
      row_q <= row_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      col_q  <= '0;
      orow_q <= '0;
    end else begin
      vld_q <= cap;
      if (cap) begin
        col_q  <= grp_q;
        orow_q <= row_q;
      end
    end
  end

  for (genvar p = 0; p < PORTS; p++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   lane_q[p] <= '0;
      else if (cap) lane_q[p] <= sens_data[p*PIX_W +: PIX_W];
    end
    assign out_data[p*PIX_W +: PIX_W] = lane_q[p];
  end

  assign start_ok     = (st_q == RD_IDLE) || (age_q >= AGE_TOP);
  assign load_shift_n = (st_q == RD_IDLE);
  assign read_en_n    = (st_q == RD_IDLE);
  assign out_valid    = vld_q;
  assign out_col      = col_q;
  assign out_row      = orow_q;
endmodule

// File: rtl/sensor_row_sequencer.sv
module sensor_row_sequencer #(
  parameter int PORTS     = 10,
  parameter int PIX_W     = 10,
  parameter int GROUPS    = 128,
  parameter int ROW_W     = 10,
  parameter int ROW_COUNT = 1024,
  parameter int TMO_W     = 16,
  parameter int LOAD_LAT  = 3,
  parameter int OVL_GAP   = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      run,
  input  logic [TMO_W-1:0]          tmo_limit,
  output logic                      row_start_n,
  output logic [ROW_W-1:0]          row_addr,
  input  logic                      row_done_n,
  output logic                      load_shift_n,
  output logic                      read_en_n,
  input  logic [PORTS*PIX_W-1:0]    sens_data,
  output logic                      frame_start,
  output logic                      err,
  output logic                      out_valid,
  output logic [PORTS*PIX_W-1:0]    out_data,
  output logic [$clog2(GROUPS)-1:0] out_col,
  output logic [ROW_W-1:0]          out_row
);
  logic [1:0]       rst_sq;
  logic             rst_i;
  logic             start_ok, take, hold;
  logic [ROW_W-1:0] hold_row;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sq <= 2'b00;
    else        rst_sq <= {rst_sq[0], 1'b1};
  end
  assign rst_i = rst_sq[1];

  rowseq_conv #(
    .ROW_W(ROW_W), .ROW_COUNT(ROW_COUNT), .TMO_W(TMO_W)
  ) u_conv (
    .clk(clk), .rst_n(rst_i), .run(run), .tmo_limit(tmo_limit),
    .start_ok(start_ok), .take(take), .row_done_n(row_done_n),
    .row_start_n(row_start_n), .row_addr(row_addr), .frame_start(frame_start),
    .hold(hold), .hold_row(hold_row), .err(err)
  );

  rowseq_readout #(
    .PORTS(PORTS), .PIX_W(PIX_W), .GROUPS(GROUPS), .ROW_W(ROW_W),
    .LOAD_LAT(LOAD_LAT), .OVL_GAP(OVL_GAP)
  ) u_readout (
    .clk(clk), .rst_n(rst_i), .hold(hold), .hold_row(hold_row),
    .sens_data(sens_data), .take(take), .start_ok(start_ok),
    .load_shift_n(load_shift_n), .read_en_n(read_en_n), .out_valid(out_valid),
    .out_data(out_data), .out_col(out_col), .out_row(out_row)
  );
endmodule

// File: rtl/rowseq_checker.sv
module rowseq_checker #(
  parameter int GROUPS    = 128,
  parameter int ROW_W     = 10,
  parameter int ROW_COUNT = 1024,
  parameter int OVL_GAP   = 2
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      row_start_n,
  input logic [ROW_W-1:0]          row_addr,
  input logic                      row_done_n,
  input logic                      load_shift_n,
  input logic                      read_en_n,
  input logic                      err,
  input logic                      out_valid,
  input logic [$clog2(GROUPS)-1:0] out_col
);
  localparam int GRP_W = $clog2(GROUPS);

  logic             done_flag, ld_prev;
  logic [7:0]       re_cnt;
  logic [GRP_W:0]   run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_flag <= 1'b0;
      ld_prev   <= 1'b1;
      re_cnt    <= '0;
      run_len   <= '0;
    end else begin
      ld_prev <= load_shift_n;
      if (!load_shift_n && ld_prev) done_flag <= !row_done_n;
      else if (!row_done_n)         done_flag <= 1'b1;
      if (read_en_n)              re_cnt <= '0;
      else if (re_cnt != 8'hFF)   re_cnt <= re_cnt + 8'd1;
      run_len <= out_valid ? run_len + 1'b1 : '0;
    end
  end

  assert_start_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !row_start_n |=> row_start_n);
  assert_addr_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    row_addr < ROW_W'(ROW_COUNT));
  assert_load_after_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(load_shift_n) |-> done_flag);
  assert_read_within_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !read_en_n |-> !load_shift_n);
  assert_valid_under_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(!load_shift_n));
  assert_col_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> out_col == '0);
  assert_col_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(out_valid)) |-> out_col == $past(out_col) + 1'b1);
  assert_row_length_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |-> run_len == (GRP_W+1)'(GROUPS));
  assert_overlap_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!row_start_n && !read_en_n) |-> re_cnt >= 8'(OVL_GAP));
  assert_no_start_on_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> row_start_n);
endmodule

bind sensor_row_sequencer rowseq_checker #(
  .GROUPS(GROUPS), .ROW_W(ROW_W), .ROW_COUNT(ROW_COUNT), .OVL_GAP(OVL_GAP)
) u_rowseq_checker (
  .clk(clk), .rst_n(rst_n), .row_start_n(row_start_n), .row_addr(row_addr),
  .row_done_n(row_done_n), .load_shift_n(load_shift_n), .read_en_n(read_en_n),
  .err(err), .out_valid(out_valid), .out_col(out_col)
);

// File: tb/sensor_row_sequencer_bench.sv
module sensor_row_sequencer_bench;
  localparam int PORTS = 10, PIX_W = 10, GROUPS = 128, ROW_W = 10;
  localparam int ROWS = 6, TMO_W = 16, TMO = 40, DONE_DLY = 4, GAP = 2, LAT = 3;
  localparam int BUS_W = PORTS*PIX_W, GRP_W = $clog2(GROUPS);

  logic clk = 1'b0;
  logic rst_n, run, row_done_n, row_start_n, load_shift_n, read_en_n;
  logic frame_start, err, out_valid;
  logic [TMO_W-1:0] tmo_limit;
  logic [ROW_W-1:0] row_addr, out_row;
  logic [BUS_W-1:0] sens_data, out_data;
  logic [GRP_W-1:0] out_col;

  always #4 clk = ~clk;

  sensor_row_sequencer #(.ROW_COUNT(ROWS), .TMO_W(TMO_W)) u_sensor_row_sequencer (
    .clk(clk), .rst_n(rst_n), .run(run), .tmo_limit(tmo_limit),
    .row_start_n(row_start_n), .row_addr(row_addr), .row_done_n(row_done_n),
    .load_shift_n(load_shift_n), .read_en_n(read_en_n), .sens_data(sens_data),
    .frame_start(frame_start), .err(err), .out_valid(out_valid),
    .out_data(out_data), .out_col(out_col), .out_row(out_row)
  );

  int checks = 0, errors = 0;
  int n_starts = 0, frames = 0, rows_done = 0, overlaps = 0;
  int exp_row = 0, cur_rd_row = 0, k = 0, done_cnt = 0, cyc = 0, re_fall = 0;
  bit mute = 0, done_seen = 0, ld_prev = 1;
  logic [ROW_W+GRP_W+BUS_W-1:0] exp_q [$];
  int rd_rows [$];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [BUS_W-1:0] pix_word(input int r, input int g);
    logic [BUS_W-1:0] w;
    for (int p = 0; p < PORTS; p++) w[p*PIX_W +: PIX_W] = PIX_W'(r*37 + 10*g + p + 1);
    return w;
  endfunction

  task automatic push_row(input int r);
    for (int g = 0; g < GROUPS; g++)
      exp_q.push_back({ROW_W'(r), GRP_W'(g), pix_word(r, g)});
    rd_rows.push_back(r);
  endtask

  // sensor model and protocol observer
  initial begin
    row_done_n = 1'b1;
    sens_data  = '0;
    forever begin
      @(negedge clk);
      cyc++;
      row_done_n = 1'b1;
      if (rst_n) begin
        if (!row_start_n) begin
          n_starts++;
          check(row_addr == ROW_W'(exp_row), "R2", "row address at start", row_addr, exp_row);
          check(frame_start == (exp_row == 0), "R3", "frame_start at start", frame_start, exp_row == 0);
          if (frame_start) frames++;
          if (!load_shift_n) begin
            overlaps++;
            check(cyc - re_fall == GAP, "R8", "start distance from read enable", cyc - re_fall, GAP);
          end
          if (!mute) begin
            push_row(exp_row);
            done_cnt = DONE_DLY;
          end
          exp_row = (exp_row + 1) % ROWS;
        end else begin
          check(!frame_start, "R3", "frame_start without start", frame_start, 0);
        end
        if (done_cnt > 0) begin
          done_cnt--;
          if (done_cnt == 0) begin
            row_done_n = 1'b0;
            done_seen  = 1;
          end
        end
        if (!load_shift_n && ld_prev) begin
          check(done_seen, "R4", "load fell without done", 0, 1);
          check(!read_en_n, "R4", "read enable with load", read_en_n, 0);
          done_seen = 0;
          re_fall = cyc;
          if (rd_rows.size() > 0) cur_rd_row = rd_rows.pop_front();
        end
        ld_prev = load_shift_n;
      end
      if (load_shift_n) k = 0;
      else k++;
      if (k >= LAT && k - LAT < GROUPS) sens_data = pix_word(cur_rd_row, k - LAT);
      else sens_data = {BUS_W{1'b1}} ^ BUS_W'(k);
    end
  end

  // scoreboard monitor
  initial begin
    logic [ROW_W+GRP_W+BUS_W-1:0] e;
    int vlen = 0;
    forever begin
      @(negedge clk);
      if (rst_n && out_valid) begin
        vlen++;
        if (exp_q.size() == 0) begin
          check(0, "R6", "unexpected output word", out_col, 0);
        end else begin
          e = exp_q.pop_front();
          check(out_data == e[BUS_W-1:0], "R5 R7", "pixel group data", out_data, e[BUS_W-1:0]);
          check({out_row, out_col} == e[ROW_W+GRP_W+BUS_W-1:BUS_W], "R6", "row and column tag",
                {out_row, out_col}, e[ROW_W+GRP_W+BUS_W-1:BUS_W]);
        end
      end else if (vlen != 0) begin
        check(vlen == GROUPS, "R6", "valid run length", vlen, GROUPS);
        rows_done++;
        vlen = 0;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int s0;
    rst_n = 1'b0;
    run = 1'b0;
    tmo_limit = TMO_W'(TMO);
    repeat (3) @(negedge clk);
    check(row_start_n && load_shift_n && read_en_n, "R1", "strobes in reset",
          {row_start_n, load_shift_n, read_en_n}, 3'b111);
    check(!out_valid && !frame_start && !err, "R1", "flags in reset",
          {out_valid, frame_start, err}, 0);
    check(row_addr == 0, "R1", "row address in reset", row_addr, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R2 R3 R5 R6 R8: continuous run past the address wrap
    run = 1'b1;
    while (rows_done < ROWS + 2) @(negedge clk);
    check(frames >= 2, "R3", "frames seen across wrap", frames, 2);
    check(overlaps >= ROWS, "R8", "overlapped starts", overlaps, ROWS);

    // R10: stop issuing, drain in-flight row
    run = 1'b0;
    repeat (300) @(negedge clk);
    s0 = n_starts;
    repeat (300) @(negedge clk);
    check(n_starts == s0, "R10", "starts with run low", n_starts, s0);
    check(exp_q.size() == 0, "R10", "words left undelivered", exp_q.size(), 0);
    check(load_shift_n && read_en_n, "R10", "enables idle", {load_shift_n, read_en_n}, 2'b11);

    // R9: conversion-done timeout
    mute = 1;
    s0 = n_starts;
    run = 1'b1;
    repeat (TMO) @(negedge clk);
    check(!err, "R9", "err before limit", err, 0);
    repeat (4) @(negedge clk);
    check(err, "R9", "err after limit", err, 1);
    repeat (100) @(negedge clk);
    check(n_starts == s0 + 1, "R9", "starts while err", n_starts, s0 + 1);
    check(load_shift_n, "R9", "no load without done", load_shift_n, 1);
    run = 1'b0;
    repeat (2) @(negedge clk);
    check(!err, "R9", "err after run low", err, 0);
    check(row_addr == ROW_W'(exp_row), "R2", "address after timed-out row", row_addr, exp_row);
    mute = 0;

    // R2 R6: one more row after recovery
    s0 = rows_done;
    run = 1'b1;
    while (n_starts == 0 || rows_done == s0) @(negedge clk);
    run = 1'b0;
    repeat (400) @(negedge clk);
    check(exp_q.size() == 0, "R6", "words left after recovery", exp_q.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule